// File: doc/BRIEF.md
# Exception Entry Controller

This block sits beside the state registers of a small RISC core and decides, each clock cycle, whether the core must enter an exception. Three sources compete. The first is a synchronous exception raised by the instruction stream, together with its cause number. The second is a tick-timer interrupt. The third is an external interrupt. Each interrupt is qualified by its own enable bit in the status word.

When an entry is taken, the block computes everything the core must load, and it presents those values one clock later in a single registered step. It produces the saved return address, corrected for delay slots and system calls. It produces a copy of the old status word and the new status word. It drives the delay-slot flag to zero. It raises a redirect strobe with the vector address, and it pulses a request to flush the translation buffers.

The core loads `sr_o` and `dslot_o` on every cycle. These two outputs simply follow the core's own values, one cycle later, when no entry is being made. The core loads `epc_o`, `esr_o` and the program counter, the last from `vector_o`, only when `redirect_o` is high.

A synchronous request whose cause is not a defined vector does not redirect. It raises a one-cycle error pulse instead.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every output is driven to zero.
- R2: Priority among the sources in one cycle is fixed. A synchronous request comes first, then the tick timer, then the external interrupt. A pending synchronous request with an invalid cause also blocks both interrupts in that cycle.
- R3: The tick timer qualifies only when status bit 1 (timer enable) is set. The external interrupt qualifies only when status bit 2 (interrupt enable) is set. A request that does not qualify produces no redirect, no flush and no error, and leaves `epc_o`, `esr_o` and `vector_o` unchanged.
- R4: On entry, `epc_o` takes the sampled PC. It is 4 lower when `dslot_i` was set and 4 higher when the cause is the system call (12). Both corrections apply together, and the arithmetic wraps modulo 2^32.
- R5: On entry, `esr_o` takes the sampled status word unchanged.
- R6: On entry, `sr_o` equals the sampled status word with the following changes:
  - bits 1, 2, 5 and 6 (timer enable, interrupt enable, data-MMU enable, instruction-MMU enable) are cleared;
  - bit 0 (supervisor) is set;
  - bit 13 (delay-slot marker) is set when `dslot_i` was set.

  On entry `dslot_o` is 0. Without an entry, `sr_o` and `dslot_o` repeat the previous cycle's `sr_i` and `dslot_i`.
- R7: On entry, `vector_o` is the cause number shifted left by 8. The cause numbers are: tick timer 5, external interrupt 8, synchronous request the value on `sync_cause_i`. Valid synchronous causes are 1 to 14.
- R8: A synchronous request with cause 0 or 15 raises `error_o` for one cycle. It raises neither `redirect_o` nor `flush_o`, and it leaves `epc_o`, `esr_o` and `vector_o` unchanged.
- R9: Every redirect is accompanied by `flush_o` in the same cycle. Both are one-cycle pulses, and every request presented in the cycle in which `redirect_o` is high is ignored.
- R10: All outputs are registered. Inputs sampled at one rising edge determine the outputs seen after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 32 | Address of the current instruction |
| sr_i | input | 32 | Current status word |
| dslot_i | input | 1 | Current instruction sits in a delay slot |
| ext_irq_i | input | 1 | External interrupt request (level) |
| tick_irq_i | input | 1 | Tick-timer interrupt request (level) |
| sync_req_i | input | 1 | Synchronous exception request |
| sync_cause_i | input | 4 | Cause number of the synchronous request |
| epc_o | output | 32 | Saved return address |
| esr_o | output | 32 | Saved status word |
| sr_o | output | 32 | Status word to load |
| dslot_o | output | 1 | Delay-slot flag to load |
| redirect_o | output | 1 | Entry pulse; load PC from vector_o |
| vector_o | output | 32 | Exception vector address |
| flush_o | output | 1 | Translation-buffer flush pulse |
| error_o | output | 1 | Undefined synchronous cause pulse |

## Verification
Several things can land in one cycle:
- all three sources together;
- a delay-slot correction together with the system-call correction of the return address;
- a fresh request arriving in the very cycle in which the previous redirect is being presented.

Directed cycles provoke each of these combinations. The expected winner, return address and status word are then compared field by field against a bench model. Random cycles with biased enables and rare synchronous requests then mix all of these with invalid causes. The model's rule that a redirect cycle swallows the next request is what judges the overlap.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    // Defined cause space: indices 1 .. NUM_CAUSES-1 carry a vector.
    localparam int NUM_CAUSES = 15;
    localparam int CAUSE_W    = $clog2(NUM_CAUSES + 1);

    // Fixed cause encodings used by the arbiter and the return-address fixup.
    localparam logic [CAUSE_W-1:0] CAUSE_TICK    = CAUSE_W'(5);
    localparam logic [CAUSE_W-1:0] CAUSE_EXT     = CAUSE_W'(8);
    localparam logic [CAUSE_W-1:0] CAUSE_SYSCALL = CAUSE_W'(12);

    // Status word bit positions.
    localparam int SRB_SUPV  = 0;
    localparam int SRB_TMREN = 1;
    localparam int SRB_IRQEN = 2;
    localparam int SRB_DMMU  = 5;
    localparam int SRB_IMMU  = 6;
    localparam int SRB_DSMRK = 13;

    // Outcome of one arbitration round.
    typedef struct packed {
        logic               take;   // valid entry selected
        logic               bad;    // synchronous request with undefined cause
        logic [CAUSE_W-1:0] cause;  // selected cause index
    } pick_t;

    function automatic logic cause_defined(input logic [CAUSE_W-1:0] c);
        return (c != '0) && (int'(c) < NUM_CAUSES);
    endfunction

endpackage

// File: rtl/exc_cause_arb.sv
module exc_cause_arb
    import exc_entry_pkg::*;
(
    input  logic               en_i,
    input  logic               sync_req_i,
    input  logic [CAUSE_W-1:0] sync_cause_i,
    input  logic               tick_i,
    input  logic               ext_i,
    input  logic               tmren_i,
    input  logic               irqen_i,
    output pick_t              pick_o
);

    always_comb begin
        pick_o = '0;
        if (en_i) begin
            if (sync_req_i) begin
                if (cause_defined(sync_cause_i)) begin
                    pick_o.take  = 1'b1;
                    pick_o.cause = sync_cause_i;
                end else begin
                    pick_o.bad = 1'b1;
                end
            end else if (tick_i && tmren_i) begin
                pick_o.take  = 1'b1;
                pick_o.cause = CAUSE_TICK;
            end else if (ext_i && irqen_i) begin
                pick_o.take  = 1'b1;
                pick_o.cause = CAUSE_EXT;
            end
        end
    end

endmodule

// File: rtl/exc_epc_calc.sv
module exc_epc_calc #(
    parameter int XLEN = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic            dslot_i,
    input  logic            syscall_i,
    output logic [XLEN-1:0] epc_o
);

    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    logic [XLEN-1:0] back;
    logic [XLEN-1:0] fwd;

    always_comb begin
        back  = dslot_i   ? STEP : '0;
        fwd   = syscall_i ? STEP : '0;
        epc_o = pc_i - back + fwd;
    end

endmodule

// File: rtl/exc_sr_update.sv
module exc_sr_update
    import exc_entry_pkg::*;
#(
    parameter int SR_W = 32
) (
    input  logic [SR_W-1:0] sr_i,
    input  logic            dslot_i,
    output logic [SR_W-1:0] sr_o
);

    localparam logic [SR_W-1:0] CLR_MASK =
        (SR_W'(1) << SRB_TMREN) | (SR_W'(1) << SRB_IRQEN) |
        (SR_W'(1) << SRB_DMMU)  | (SR_W'(1) << SRB_IMMU);
    localparam logic [SR_W-1:0] SET_SUPV  = SR_W'(1) << SRB_SUPV;
    localparam logic [SR_W-1:0] SET_DSMRK = SR_W'(1) << SRB_DSMRK;

    always_comb begin
        sr_o = (sr_i & ~CLR_MASK) | SET_SUPV;
        if (dslot_i) begin
            sr_o = sr_o | SET_DSMRK;
        end
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int SR_W      = 32,
    parameter int VEC_SHIFT = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [XLEN-1:0]    pc_i,
    input  logic [SR_W-1:0]    sr_i,
    input  logic               dslot_i,
    input  logic               ext_irq_i,
    input  logic               tick_irq_i,
    input  logic               sync_req_i,
    input  logic [CAUSE_W-1:0] sync_cause_i,
    output logic [XLEN-1:0]    epc_o,
    output logic [SR_W-1:0]    esr_o,
    output logic [SR_W-1:0]    sr_o,
    output logic               dslot_o,
    output logic               redirect_o,
    output logic [XLEN-1:0]    vector_o,
    output logic               flush_o,
    output logic               error_o
);

    pick_t           pick;
    logic            arb_en;
    logic [XLEN-1:0] epc_next;
    logic [SR_W-1:0] sr_entry;
    logic [XLEN-1:0] vec_next;

    // A request is not considered while the previous entry is being presented.
    assign arb_en   = !redirect_o;
    assign vec_next = XLEN'(pick.cause) << VEC_SHIFT;

    exc_cause_arb u_arb (
        .en_i         (arb_en),
        .sync_req_i   (sync_req_i),
        .sync_cause_i (sync_cause_i),
        .tick_i       (tick_irq_i),
        .ext_i        (ext_irq_i),
        .tmren_i      (sr_i[SRB_TMREN]),
        .irqen_i      (sr_i[SRB_IRQEN]),
        .pick_o       (pick)
    );

    exc_epc_calc #(.XLEN(XLEN)) u_epc (
        .pc_i      (pc_i),
        .dslot_i   (dslot_i),
        .syscall_i (pick.cause == CAUSE_SYSCALL),
        .epc_o     (epc_next)
    );

    exc_sr_update #(.SR_W(SR_W)) u_sr (
        .sr_i    (sr_i),
        .dslot_i (dslot_i),
        .sr_o    (sr_entry)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            epc_o      <= '0;
            esr_o      <= '0;
            sr_o       <= '0;
            dslot_o    <= 1'b0;
            redirect_o <= 1'b0;
            vector_o   <= '0;
            flush_o    <= 1'b0;
            error_o    <= 1'b0;
        end else begin
            redirect_o <= pick.take;
            flush_o    <= pick.take;
            error_o    <= pick.bad;
            if (pick.take) begin
                epc_o    <= epc_next;
                esr_o    <= sr_i;
                sr_o     <= sr_entry;
                dslot_o  <= 1'b0;
                vector_o <= vec_next;
            end else begin
                sr_o     <= sr_i;
                dslot_o  <= dslot_i;
            end
        end
    end

    AST_ERR_NO_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        error_o |-> !redirect_o && !flush_o);  // R8

    AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
        error_o |-> $stable(epc_o) && $stable(esr_o) && $stable(vector_o));  // R8

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        redirect_o |=> !redirect_o);  // R9

    AST_FLUSH_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
        redirect_o |-> flush_o);  // R9

    AST_SUPERVISOR_ENTRY: assert property (@(posedge clk) disable iff (rst)
        redirect_o |-> sr_o[SRB_SUPV] && !sr_o[SRB_TMREN] && !sr_o[SRB_IRQEN]
                       && !sr_o[SRB_DMMU] && !sr_o[SRB_IMMU] && !dslot_o);  // R6

    AST_DSLOT_MARK: assert property (@(posedge clk) disable iff (rst)
        (redirect_o && $past(dslot_i)) |-> sr_o[SRB_DSMRK]);  // R6

    AST_ESR_COPY: assert property (@(posedge clk) disable iff (rst)
        redirect_o |-> esr_o == $past(sr_i));  // R5

    AST_VECTOR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        redirect_o |-> (vector_o[VEC_SHIFT-1:0] == '0) && (vector_o != '0));  // R7

endmodule

// File: tb/exc_entry_ctrl_bench.sv
`timescale 1ns/1ps
module exc_entry_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_i = '0;
    logic [31:0] sr_i = '0;
    logic        dslot_i = 1'b0;
    logic        ext_irq_i = 1'b0;
    logic        tick_irq_i = 1'b0;
    logic        sync_req_i = 1'b0;
    logic [3:0]  sync_cause_i = '0;
    logic [31:0] epc_o, esr_o, sr_o, vector_o;
    logic        dslot_o, redirect_o, flush_o, error_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Model state: expected outputs after the next edge.
    logic [31:0] m_epc = '0, m_esr = '0, m_sr = '0, m_vec = '0;
    logic        m_ds = 1'b0, m_red = 1'b0, m_fl = 1'b0, m_err = 1'b0;

    always #5 clk = ~clk;

    exc_entry_ctrl u_exc_entry_ctrl (
        .clk(clk), .rst(rst), .pc_i(pc_i), .sr_i(sr_i), .dslot_i(dslot_i),
        .ext_irq_i(ext_irq_i), .tick_irq_i(tick_irq_i), .sync_req_i(sync_req_i),
        .sync_cause_i(sync_cause_i), .epc_o(epc_o), .esr_o(esr_o), .sr_o(sr_o),
        .dslot_o(dslot_o), .redirect_o(redirect_o), .vector_o(vector_o),
        .flush_o(flush_o), .error_o(error_o)
    );

    function automatic logic [31:0] entry_sr(input logic [31:0] sr, input logic ds);
        logic [31:0] r;
        r = sr & ~32'h0000_0066;   // clear bits 1,2,5,6
        r = r | 32'h1;             // supervisor bit 0
        if (ds) r = r | 32'h2000;  // delay-slot marker bit 13
        return r;
    endfunction

    task automatic model_step();
        logic       tk, bd;
        logic [3:0] c;
        tk = 1'b0; bd = 1'b0; c = '0;
        if (!m_red) begin                           // R9: swallowed after entry
            if (sync_req_i) begin                   // R2: synchronous first
                if (sync_cause_i == 4'd0 || sync_cause_i == 4'd15) bd = 1'b1;
                else begin tk = 1'b1; c = sync_cause_i; end
            end else if (tick_irq_i && sr_i[1]) begin tk = 1'b1; c = 4'd5; end
            else if (ext_irq_i && sr_i[2]) begin tk = 1'b1; c = 4'd8; end
        end
        m_red = tk; m_fl = tk; m_err = bd;
        if (tk) begin
            m_epc = pc_i - (dslot_i ? 32'd4 : 32'd0) + ((c == 4'd12) ? 32'd4 : 32'd0);
            m_esr = sr_i;
            m_sr  = entry_sr(sr_i, dslot_i);
            m_ds  = 1'b0;
            m_vec = {28'd0, c} << 8;
        end else begin
            m_sr = sr_i;
            m_ds = dslot_i;
        end
    endtask

    task automatic chk(input string note, input string field, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s act=%h exp=%h", note, field, act, exp);
        end
    endtask

    task automatic compare(input string note);
        chk(note, "redirect (R7)", {31'd0, redirect_o}, {31'd0, m_red});
        chk(note, "flush (R9)",    {31'd0, flush_o},    {31'd0, m_fl});
        chk(note, "vector (R7)",   vector_o, m_vec);
        chk(note, "epc (R4)",      epc_o, m_epc);
        chk(note, "esr (R5)",      esr_o, m_esr);
        chk(note, "sr (R6)",       sr_o, m_sr);
        chk(note, "dslot (R6)",    {31'd0, dslot_o}, {31'd0, m_ds});
        chk(note, "error (R8)",    {31'd0, error_o}, {31'd0, m_err});
    endtask

    // Drive at a falling edge, compare at the next falling edge (R10).
    task automatic drive(input logic [31:0] pc, input logic [31:0] sr, input logic ds,
                         input logic ext, input logic tick, input logic sreq,
                         input logic [3:0] cause, input string note);
        pc_i = pc; sr_i = sr; dslot_i = ds; ext_irq_i = ext; tick_irq_i = tick;
        sync_req_i = sreq; sync_cause_i = cause;
        model_step();
        @(negedge clk);
        compare(note);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        compare("R1 reset values");
        rst = 1'b0;

        drive(32'h1000, 32'h4, 0, 1, 0, 0, 0, "R3 ext taken with enable");
        drive(32'h1004, 32'h0, 0, 0, 0, 0, 0, "R9 idle after entry");
        drive(32'h1008, 32'h0, 0, 1, 0, 0, 0, "R3 ext masked");
        drive(32'h100C, 32'h4, 0, 0, 1, 0, 0, "R3 tick masked");
        drive(32'h1010, 32'h6, 0, 1, 1, 0, 0, "R2 timer over external");
        drive(32'h1014, 32'h0, 0, 0, 0, 0, 0, "R9 idle");
        drive(32'h2000, 32'h66, 1, 1, 1, 1, 4'd12, "R2 sync first, R4 syscall in delay slot");
        drive(32'h2004, 32'h0, 0, 0, 0, 0, 0, "R9 idle");
        drive(32'h3000, 32'h6, 0, 1, 1, 1, 4'd0, "R8 cause zero blocks irqs");
        drive(32'h3004, 32'h6, 0, 0, 0, 1, 4'd15, "R8 cause fifteen");
        drive(32'h3008, 32'hFFFF_FFFF, 0, 0, 0, 1, 4'd14, "R7 highest valid cause");
        drive(32'h300C, 32'h6, 0, 1, 1, 1, 4'd3, "R9 request during redirect ignored");
        drive(32'h3010, 32'h0, 0, 0, 0, 1, 4'd3, "R7 sync cause three");
        drive(32'h0, 32'h4, 0, 0, 0, 0, 0, "R9 idle");
        drive(32'h0, 32'h4, 1, 1, 0, 0, 0, "R4 delay slot wrap");
        drive(32'h40, 32'h2, 0, 0, 1, 0, 0, "R9 held tick swallowed");
        drive(32'h40, 32'h2, 0, 0, 1, 0, 0, "R7 held tick retaken");

        for (int i = 0; i < 3000; i++) begin
            drive($urandom & 32'hFFFF_FFFC, $urandom, ($urandom % 4) == 0,
                  $urandom % 2 == 0, $urandom % 2 == 0, ($urandom % 5) == 0,
                  4'($urandom % 16), "R10 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule